// File: doc/BRIEF.md
# Serial Byte-Addressed Memory Slave

This block is a serial-bus memory target. A host selects it with an active-low chip select, clocks an op-code, a two-byte address and data over a four-wire synchronous serial link, and reads or writes a byte-wide storage array held inside the block. Every write lands in the array as soon as its last bit arrives, so the host can start the next transaction at once without polling for a ready state. Streaming transfers walk an address counter forward one byte at a time. A write-enable latch must be armed before any array or status write is accepted. An active-low protect pin can lock the status register without affecting the array.

All pins are brought into a single system clock domain through two-flop synchronizers and the serial clock is edge-detected there. The serial clock's high and low phases must each last at least four system clock cycles. The array depth is set by `ADDR_W`. Its default of 11 bits (2048 bytes) keeps elaboration small, and `ADDR_W = 15` gives the full 32K x 8 part. A hold input pauses a transfer at any bit and releases the output pin. The host drives the serial clock in either idle polarity, low or high, and the block notes which one is in use at each chip-select fall.

Top module: `spi_mem_slave`

## Requirements
- R1: The address follows the op-code as two bytes, high byte first. Only the low `ADDR_W` bits of that 16-bit field select a byte, and the bits above them are ignored.
- R2: Input bits are taken on rising serial-clock edges and output bits change on falling edges. A transfer works the same whether the clock idles low or high, and a falling edge before the first rising edge of a selection is not treated as a shift.
- R3: The first byte of each selection is the op-code: 0x06 arm, 0x04 disarm, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. A second op-code in the same selection is ignored, and so is any unknown op-code, until chip select goes high.
- R4: Op-code 0x06 sets the write-enable latch and 0x04 clears it. The latch shows as bit 1 of the status byte.
- R5: The latch clears when chip select rises after a write (0x02) or write-status (0x01) command. While the latch is clear, array and status writes are ignored.
- R6: During streaming reads and writes the address advances by one after each byte and wraps from the top address to 0.
- R7: The status byte is {stored bits 7:2, latch, 0}. After reset it is 0x00. Bits 7:2 are written by the first data byte of op-code 0x01. During op-code 0x05 the status byte repeats for as long as clocks continue.
- R8: While the protect pin `wp_n` is low, status writes are ignored. Array writes still succeed.
- R9: `so_oe` is high only while read or status data is being shifted out. It is low while chip select is high.
- R10: While `hold_n` is low, serial-clock and chip-select edges are ignored and `so_oe` is low. When `hold_n` goes high the transfer resumes at the bit where it stopped.
- R11: A byte written by one transaction can be read back by the very next transaction, with no busy time between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Status write protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |

## Verification
The bench writes past the top address. A design that failed to wrap the counter would scatter those bytes, and one that honoured the ignored upper address bits would read the wrong byte back. It sends a disarm op-code inside a selection that already carries an arm op-code. A block that decoded more than one op-code per selection would then report the latch as clear. It pauses a read mid-byte with hold and toggles the clock during the pause. A design that counted those edges, or kept driving the pin, would return a shifted byte or show the output enabled. It also writes status with the protect pin low, repeats a read with the clock idling high, and writes without arming, where a leaky guard would change the stored data.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OPC_ARM    = 8'h06;
  localparam logic [7:0] OPC_DISARM = 8'h04;
  localparam logic [7:0] OPC_RDSTAT = 8'h05;
  localparam logic [7:0] OPC_WRSTAT = 8'h01;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_WRITE  = 8'h02;

  typedef enum logic [2:0] {
    S_OPC, S_ADDH, S_ADDL, S_WDATA, S_RDATA, S_WSTAT, S_RSTAT, S_IGN
  } ph_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_WRSTAT
  } op_t;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          si_s,
  input  logic          hold_n_s,
  input  logic          wp_n_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_wa,
  output logic [7:0]    mem_wd,
  output logic [AW-1:0] mem_ra,
  input  logic [7:0]    mem_rd,
  output logic          so_q,
  output logic          so_oe_q
);
  localparam int HIW = AW - 8;

  ph_t            st;
  op_t            op;
  logic [2:0]     cnt;
  logic [6:0]     sh;
  logic [HIW-1:0] ahi;
  logic [AW-1:0]  addr;
  logic [7:0]     ob;
  logic           wel;
  logic [5:0]     user;
  logic           armed, skip, fetch, fetch2, sck_p, cs_p;

  logic       rise, fall, cs_fall, cs_rise;
  logic [7:0] inb, stat;

  assign rise    = hold_n_s & ~cs_n_s & sck_s & ~sck_p;
  assign fall    = hold_n_s & ~cs_n_s & ~sck_s & sck_p;
  assign cs_fall = hold_n_s & cs_p & ~cs_n_s;
  assign cs_rise = hold_n_s & ~cs_p & cs_n_s;
  assign inb     = {sh, si_s};
  assign stat    = {user, wel, 1'b0};
  assign mem_ra  = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OPC; op <= OP_NONE; cnt <= '0; sh <= '0; ahi <= '0;
      addr <= '0; ob <= '0; wel <= 1'b0; user <= '0; armed <= 1'b0;
      skip <= 1'b0; fetch <= 1'b0; fetch2 <= 1'b0; sck_p <= 1'b0;
      cs_p <= 1'b1; so_q <= 1'b0; so_oe_q <= 1'b0; mem_we <= 1'b0;
      mem_wa <= '0; mem_wd <= '0;
    end else begin
      mem_we  <= 1'b0;
      fetch   <= 1'b0;
      fetch2  <= fetch;
      so_oe_q <= armed & ~cs_n_s & hold_n_s;
      if (hold_n_s) begin
        sck_p <= sck_s;
        cs_p  <= cs_n_s;
      end
      if (fetch2) ob <= mem_rd;
      if (cs_fall) begin
        skip <= sck_s;
        st   <= S_OPC;
        op   <= OP_NONE;
        cnt  <= '0;
      end
      if (cs_rise) begin
        if (op == OP_WRITE || op == OP_WRSTAT) wel <= 1'b0;
        st    <= S_OPC;
        op    <= OP_NONE;
        cnt   <= '0;
        armed <= 1'b0;
      end
      if (rise) begin
        skip <= 1'b0;
        sh   <= inb[6:0];
        cnt  <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          unique case (st)
            S_OPC: begin
              if (inb == OPC_ARM) begin
                wel <= 1'b1; st <= S_IGN;
              end else if (inb == OPC_DISARM) begin
                wel <= 1'b0; st <= S_IGN;
              end else if (inb == OPC_RDSTAT) begin
                ob <= stat; st <= S_RSTAT;
              end else if (inb == OPC_WRSTAT) begin
                op <= OP_WRSTAT; st <= S_WSTAT;
              end else if (inb == OPC_READ) begin
                op <= OP_READ; st <= S_ADDH;
              end else if (inb == OPC_WRITE) begin
                op <= OP_WRITE; st <= S_ADDH;
              end else begin
                st <= S_IGN;
              end
            end
            S_ADDH: begin
              ahi <= inb[HIW-1:0];
              st  <= S_ADDL;
            end
            S_ADDL: begin
              addr <= {ahi, inb};
              if (op == OP_READ) begin
                st <= S_RDATA; fetch <= 1'b1;
              end else begin
                st <= S_WDATA;
              end
            end
            S_WDATA: begin
              if (wel) begin
                mem_we <= 1'b1; mem_wa <= addr; mem_wd <= inb;
              end
              addr <= addr + 1'b1;
            end
            S_RDATA: begin
              addr <= addr + 1'b1; fetch <= 1'b1;
            end
            S_RSTAT: ob <= stat;
            S_WSTAT: begin
              if (wel && wp_n_s) user <= inb[7:2];
              st <= S_IGN;
            end
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (skip) begin
          skip <= 1'b0;
        end else if (st == S_RDATA || st == S_RSTAT) begin
          so_q  <= ob[7];
          ob    <= {ob[6:0], 1'b0};
          armed <= 1'b1;
        end
      end
    end
  end

  // R5: an array write reaches the memory only with the latch set
  assert_array_write_needs_latch_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  // R8 / R5: stored status bits change only when protect was high and latch set
  assert_status_guard_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(user) |-> ($past(wp_n_s) && $past(wel)));

  // R6: write address wraps to zero after the top byte
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (rise && st == S_WDATA && cnt == 3'd7 && addr == '1) |=> (addr == '0));

  // R4: disarm op-code clears the latch
  assert_disarm_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rise && st == S_OPC && cnt == 3'd7 && inb == OPC_DISARM) |=> !wel);

  // R9: output is armed only inside a read phase
  assert_oe_in_read_R9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (st == S_RDATA || st == S_RSTAT));

  // R10: transfer state is frozen while hold is low
  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (rst)
    !hold_n_s |=> ($stable(cnt) && $stable(st) && $stable(addr)));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int NPIN = 5;

  logic [NPIN-1:0] pins_s;
  logic            cs_n_s, sck_s, si_s, hold_n_s, wp_n_s;
  logic            mem_we;
  logic [ADDR_W-1:0] mem_wa, mem_ra;
  logic [7:0]      mem_wd, mem_rd;

  spi_mem_sync #(.W(NPIN), .RST_VAL(5'b11001)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, hold_n, sck, si, wp_n}),
    .q(pins_s)
  );
  assign {cs_n_s, hold_n_s, sck_s, si_s, wp_n_s} = pins_s;

  spi_mem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s),
    .hold_n_s(hold_n_s), .wp_n_s(wp_n_s), .mem_we(mem_we), .mem_wa(mem_wa),
    .mem_wd(mem_wd), .mem_ra(mem_ra), .mem_rd(mem_rd), .so_q(so), .so_oe_q(so_oe)
  );

  spi_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(mem_ra), .rd(mem_rd)
  );

  // R9: a deselected device releases its output on the next cycle
  assert_release_when_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !so_oe);
endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8 * CLK_PERIOD;
  localparam int AW = 11;
  localparam logic [15:0] AMASK = 16'((1 << AW) - 1);

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_mem_slave #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t       expq[$];
  logic [7:0] rxq[$];
  logic [7:0] model_mem [0:(1<<AW)-1];
  bit         model_wel = 0;
  logic [5:0] model_user = '0;
  bit         mode3 = 0;
  bit         done = 0;
  int         checks = 0, errors = 0;

  task automatic note(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_exp();
    return {model_user, model_wel, 1'b0};
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      wait (rxq.size() > 0);
      begin
        logic [7:0] r;
        exp_t e;
        r = rxq.pop_front();
        e = expq.pop_front();
        note(r === e.v, e.tag, "read byte", {24'h0, r}, {24'h0, e.v});
      end
    end
  end

  task automatic bit_x(input logic b, output logic r, output logic oe);
    sck = 1'b0; si = b;
    #HALF;
    sck = 1'b1; r = so; oe = so_oe;
    #HALF;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    logic r, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r, oe);
      rx[i] = r;
      oe_all &= oe;
    end
  endtask

  task automatic sel();
    sck = mode3; #HALF;
    cs_n = 1'b0; #HALF;
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    #HALF;
    cs_n = 1'b1;
    #(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx; logic oe;
    sel(); byte_x(op, rx, oe); desel();
    if (op == 8'h06) model_wel = 1;
    if (op == 8'h04) model_wel = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d[$]);
    logic [7:0] rx; logic oe;
    sel();
    byte_x(8'h02, rx, oe); byte_x(a[15:8], rx, oe); byte_x(a[7:0], rx, oe);
    foreach (d[i]) byte_x(d[i], rx, oe);
    desel();
    if (model_wel) foreach (d[i]) model_mem[(a + 16'(i)) & AMASK] = d[i];
    model_wel = 0;
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string tag);
    logic [7:0] rx; logic oe;
    sel();
    byte_x(8'h03, rx, oe); byte_x(a[15:8], rx, oe); byte_x(a[7:0], rx, oe);
    for (int i = 0; i < n; i++) begin
      expq.push_back('{model_mem[(a + 16'(i)) & AMASK], tag});
      byte_x(8'h00, rx, oe);
      rxq.push_back(rx);
      note(oe, "R9", "so_oe during read data", {31'h0, oe}, 1);
    end
    desel();
    note(so_oe == 1'b0, "R9", "so_oe after deselect", {31'h0, so_oe}, 0);
  endtask

  task automatic rdsr(input int n, input string tag);
    logic [7:0] rx; logic oe;
    sel();
    byte_x(8'h05, rx, oe);
    for (int i = 0; i < n; i++) begin
      expq.push_back('{stat_exp(), tag});
      byte_x(8'h00, rx, oe);
      rxq.push_back(rx);
    end
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx; logic oe;
    sel(); byte_x(8'h01, rx, oe); byte_x(v, rx, oe); desel();
    if (model_wel && wp_n) model_user = v[7:2];
    model_wel = 0;
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx; logic oe, r, oe1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    note(so_oe == 1'b0, "R9", "so_oe after reset", {31'h0, so_oe}, 0);
    rdsr(1, "R7");

    cmd(8'h06);
    rdsr(1, "R4");

    wr(16'h0010, '{8'hA5, 8'h5A, 8'h3C});
    rdsr(1, "R5");
    rd(16'h0010, 3, "R6");

    wr(16'h0010, '{8'hFF});
    rd(16'h0010, 1, "R5");

    cmd(8'h06); cmd(8'h04);
    rdsr(1, "R4");

    cmd(8'h06);
    wr(16'h87FF, '{8'h11, 8'h22});
    rd(16'h07FF, 2, "R6");
    rd(16'hF800, 1, "R1");

    cmd(8'h06); wrsr(8'hFC);
    rdsr(2, "R7");
    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h00);
    rdsr(1, "R8");
    cmd(8'h06);
    wr(16'h0020, '{8'h77});
    rd(16'h0020, 1, "R8");
    wp_n = 1'b1;

    // R3: unknown op-code leaves output idle
    sel();
    byte_x(8'hAB, rx, oe);
    byte_x(8'h00, rx, oe); byte_x(8'h00, rx, oe); byte_x(8'h00, rx, oe);
    note(oe == 1'b0, "R3", "so_oe after unknown op-code", {31'h0, oe}, 0);
    desel();
    // R3: second op-code in one selection is ignored
    sel(); byte_x(8'h06, rx, oe); byte_x(8'h04, rx, oe); desel();
    model_wel = 1;
    rdsr(1, "R3");
    cmd(8'h04);

    // R2: clock idling high
    mode3 = 1;
    rd(16'h0010, 3, "R2");
    cmd(8'h06);
    wr(16'h0040, '{8'hC3});
    rd(16'h0040, 1, "R2");
    mode3 = 0;

    // R10: hold in the middle of a read byte
    sel();
    byte_x(8'h03, rx, oe); byte_x(8'h00, rx, oe); byte_x(8'h11, rx, oe);
    for (int i = 7; i >= 4; i--) begin bit_x(1'b0, r, oe1); rx[i] = r; end
    sck = 1'b0; #HALF;
    hold_n = 1'b0; #(2 * HALF);
    note(so_oe == 1'b0, "R10", "so_oe while held", {31'h0, so_oe}, 0);
    for (int k = 0; k < 3; k++) begin sck = 1'b1; #HALF; sck = 1'b0; #HALF; end
    hold_n = 1'b1; #HALF;
    for (int i = 3; i >= 0; i--) begin bit_x(1'b0, r, oe1); rx[i] = r; end
    note(oe1 == 1'b1, "R10", "so_oe after release", {31'h0, oe1}, 1);
    expq.push_back('{model_mem[16'h0011], "R10"});
    rxq.push_back(rx);
    desel();

    // R11: back-to-back write then read
    cmd(8'h06);
    wr(16'h0030, '{8'h9C});
    rd(16'h0030, 1, "R11");

    wait (rxq.size() == 0);
    #(4 * CLK_PERIOD);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule